// File: doc/BRIEF.md
# Polled Priority Interrupt Controller

This block collects a set of interrupt request lines, for example two timers, two DMA channels and a few external pins, and lets a CPU service them by polling a register. It does not use a vectored acknowledge cycle. A rising edge on a request line latches a sticky pending bit. Each source also has a mask bit, and its priority is fixed by its index. Each source reports a 6-bit type code equal to `TYPE_BASE` plus its index.

Software reaches the block through a plain register port with write-enable, read-enable, an 8-bit address and 16-bit data. Read data is combinational from the current state. Two read-only addresses return the same poll word, which names the highest-priority unmasked pending source. A read of the consuming address (0x24) acknowledges that source, and the next candidate takes its place. A read of the peek address (0x26) changes nothing. The mask register sits at 0x28.

Top module: `polled_irq_ctrl`

## Requirements
- R1: Among the sources that are pending and unmasked, the lowest index is reported. Its type code, `TYPE_BASE` plus the index, appears in bits 5:0 of the poll word.
- R2: A source whose mask bit is 1 is never reported, but its pending bit is kept. The source is reported once its mask bit is cleared.
- R3: The mask register at address 0x28 is read/write, and bit i belongs to source i. With the default wiring, Timer0 is source 0, the two shared DMA/external sources are sources 2 and 3, and Timer1 is source 4. The register resets to all ones, and bits above `NUM_SRC` read as 0.
- R4: Bit 15 of the poll word is 1 exactly when some unmasked source is pending. Bits 14:6 always read 0, and the whole word is 0 when nothing is reported.
- R5: A 0-to-1 transition on a request line sets that source's pending bit. A line held high does not set it again after it has been acknowledged.
- R6: A read of 0x24 returns the poll word and clears the reported source's pending bit at the clock edge that ends the read. The next candidate is then reported.
- R7: A read of 0x26 returns the same word as 0x24 would, and it clears or changes no pending bit.
- R8: A rising edge on a source in the same cycle that the source is acknowledged leaves it pending.
- R9: A read of 0x24 while nothing is reported changes no state. Writes to 0x24 and 0x26 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_SRC | Interrupt request lines, rising-edge sensitive |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from current state |

## Verification
An acknowledge (a read of 0x24) and a new rising edge on the same source can occur in one clock cycle, and the set must win over the clear. The bench provokes this by raising that source's request line in the very cycle it drives the consuming read. It then peeks at 0x26 and expects the same type code again. A near-exhaustive sweep over every pending pattern, each with a different mask, also covers the ordinary case, in which an acknowledge without a coincident edge must remove the source.

// File: rtl/irq_poll_pkg.sv
// Package: shared constants and the poll-word builder for the polled
// interrupt controller. Assumes a 16-bit register data path.
package irq_poll_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 8;
    localparam int TYPE_W   = 6;
    localparam int FLAG_BIT = 15;

    localparam logic [ADDR_W-1:0] OFS_POLL = 8'h24;  // consuming read
    localparam logic [ADDR_W-1:0] OFS_PEEK = 8'h26;  // status-only read
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h28;  // mask register

    // Builds the poll word: flag in bit 15, reserved zeros, type code low.
    function automatic logic [DATA_W-1:0] make_poll_word(input logic vld,
                                                         input logic [TYPE_W-1:0] code);
        logic [DATA_W-1:0] w;
        w = '0;
        if (vld) begin
            w[FLAG_BIT]     = 1'b1;
            w[TYPE_W-1:0]   = code;
        end
        return w;
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
// Module: per-source rising-edge detector and sticky pending bit.
// Assumes ack_i has at most one bit set. An edge in the same cycle as an
// acknowledge of that source wins, so the source stays pending.
module irq_pend_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] edge_o
);
    logic [N-1:0] req_q;

    // Edge detection from the previous request sample.
    assign edge_o = req_i & ~req_q;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_src
            // Track request history; reset samples the live level so no false edge.
            always_ff @(posedge clk) begin
                if (!rst_n) req_q[g] <= req_i[g];
                else        req_q[g] <= req_i[g];
            end

            // Sticky pending: set by edge, cleared by acknowledge, set wins.
            always_ff @(posedge clk) begin
                if (!rst_n)          pend_o[g] <= 1'b0;
                else if (edge_o[g])  pend_o[g] <= 1'b1;
                else if (ack_i[g])   pend_o[g] <= 1'b0;
            end

            AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                ack_i[g] && !edge_o[g] |=> !pend_o[g]);   // R6
            AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                edge_o[g] |=> pend_o[g]);                 // R5
            AST_REEDGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                ack_i[g] && edge_o[g] |=> pend_o[g]);     // R8
        end
    endgenerate

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_i));                                 // R6
endmodule

// File: rtl/irq_prio_pick.sv
// Module: fixed-priority picker, lowest set index wins.
// Purely combinational. idx_o is meaningful only while any_o is 1.
module irq_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     cand_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from high index to low so the lowest set index is written last.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_reg_port.sv
// Module: register decode, mask register and read mux.
// Assumes single-cycle strobes. Read data is combinational. take_o flags a
// consuming read that has a source to acknowledge.
module irq_reg_port
    import irq_poll_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              any_i,
    input  logic [TYPE_W-1:0] code_i,
    output logic [N-1:0]      mask_o,
    output logic [DATA_W-1:0] rdata,
    output logic              take_o
);
    logic [DATA_W-1:0] poll_word;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;
    assign poll_word    = make_poll_word(any_i, code_i);
    assign take_o       = rd_en && (addr == OFS_POLL) && any_i;

    // Mask register: all sources masked after reset; only its own address writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_o <= '1;
        else if (wr_en && addr == OFS_MASK)  mask_o <= wdata[N-1:0];
    end

    // Read mux: both poll addresses share one word; unknown addresses read zero.
    always_comb begin
        rdata = '0;
        if (addr == OFS_POLL || addr == OFS_PEEK) rdata = poll_word;
        else if (addr == OFS_MASK)                rdata[N-1:0] = mask_o;
    end

    AST_MASK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> mask_o == '1);                         // R3
    AST_POLL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr == OFS_POLL || addr == OFS_PEEK) |=> $stable(mask_o)); // R9
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_POLL || addr == OFS_PEEK) |->
            rdata[14:6] == '0 && rdata[FLAG_BIT] == any_i);      // R4
endmodule

// File: rtl/polled_irq_ctrl.sv
// Module: top of the polled priority interrupt controller.
// Assumes NUM_SRC <= 16 and that request lines are synchronous to clk.
// Ties pending bank, picker and register port together.
module polled_irq_ctrl
    import irq_poll_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int TYPE_BASE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [7:0]         bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] pend, edges, mask, elig, ack_vec;
    logic               any, take;
    logic [IDX_W-1:0]   idx;
    logic [TYPE_W-1:0]  code;
    logic               peek_rd, empty_poll;

    assign elig = pend & ~mask;
    assign code = TYPE_W'(TYPE_BASE) + TYPE_W'(idx);

    // Acknowledge vector: one-hot on the reported source during a consuming read.
    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_ack
            assign ack_vec[g] = take && (idx == IDX_W'(g));
        end
    endgenerate

    irq_pend_bank #(.N(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_vec),
        .pend_o(pend), .edge_o(edges)
    );

    irq_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .cand_i(elig), .any_o(any), .idx_o(idx)
    );

    irq_reg_port #(.N(NUM_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
        .addr(bus_addr), .wdata(bus_wdata), .any_i(any), .code_i(code),
        .mask_o(mask), .rdata(bus_rdata), .take_o(take)
    );

    assign peek_rd    = bus_rd_en && bus_addr == OFS_PEEK;
    assign empty_poll = bus_rd_en && bus_addr == OFS_POLL && !any;

    AST_MASKED_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> !mask[idx] && pend[idx]);                                 // R2
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (elig & ((NUM_SRC'(1) << idx) - NUM_SRC'(1))) == '0);     // R1
    AST_PEEK_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        peek_rd |=> ($past(pend) & ~pend) == '0);                         // R7
    AST_EMPTY_POLL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        empty_poll |=> ($past(pend) & ~pend) == '0);                      // R9
endmodule

// File: tb/polled_irq_ctrl_tb.sv
module polled_irq_ctrl_tb;
    localparam int N = 8;
    localparam int TB = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [N-1:0] req = '0;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int checks = 0, errors = 0;
    logic [N-1:0] mdl_pend = '0;
    logic [N-1:0] mdl_mask = '1;

    always #5 clk = ~clk;

    polled_irq_ctrl #(.NUM_SRC(N), .TYPE_BASE(TB)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .bus_wr_en(wr_en),
        .bus_rd_en(rd_en), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
    );

    function automatic logic [15:0] exp_word(input logic [N-1:0] p, input logic [N-1:0] m);
        logic [N-1:0] e;
        e = p & ~m;
        for (int i = 0; i < N; i++)
            if (e[i]) return 16'h8000 | 16'(TB + i);
        return 16'h0000;
    endfunction

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic pulse(input logic [N-1:0] bits);
        @(negedge clk);
        req = bits;
        @(negedge clk);
        req = '0;
    endtask

    // Consume everything the model says is visible, checking the order.
    task automatic drain(input string tag);
        logic [15:0] d;
        int w;
        for (int k = 0; k <= N; k++) begin
            bus_read(8'h24, d);
            check(tag, d, exp_word(mdl_pend, mdl_mask));
            w = lowest(mdl_pend & ~mdl_mask);
            if (w < 0) break;
            mdl_pend[w] = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R3 reset mask, R4 empty word
        bus_read(8'h28, d); check("R3 reset mask", d, 16'h00FF);
        bus_read(8'h26, d); check("R4 empty peek", d, 16'h0000);

        // R2/R1 masked edge is retained
        pulse(8'h04); mdl_pend = 8'h04;
        bus_read(8'h26, d); check("R2 masked hidden", d, 16'h0000);

        bus_write(8'h28, 16'h0000); mdl_mask = '0;
        bus_read(8'h28, d); check("R3 mask readback", d, 16'h0000);
        drain("R2 unmask reveals");

        // R5 level held does not re-pend after acknowledge
        @(negedge clk); req = 8'h08;
        @(negedge clk);
        bus_read(8'h24, d); check("R5 held level reported", d, 16'h8000 | 16'(TB + 3));
        bus_read(8'h26, d); check("R5 held level no re-pend", d, 16'h0000);
        @(negedge clk); req = '0;
        bus_read(8'h26, d); check("R5 fall no pend", d, 16'h0000);
        pulse(8'h08);
        bus_read(8'h26, d); check("R5 new edge pends", d, 16'h8000 | 16'(TB + 3));
        mdl_pend = 8'h08; drain("R6 drain after R5");

        // R8 edge coincident with acknowledge of same source
        pulse(8'h02);
        @(negedge clk);
        req = 8'h02; rd_en = 1; addr = 8'h24;
        #1 check("R8 read word", rdata, 16'h8000 | 16'(TB + 1));
        @(negedge clk);
        rd_en = 0; req = '0;
        bus_read(8'h26, d); check("R8 still pending", d, 16'h8000 | 16'(TB + 1));
        mdl_pend = 8'h02; drain("R8 drain");

        // R9 writes to poll addresses ignored
        pulse(8'h20); mdl_pend = 8'h20;
        bus_write(8'h24, 16'hFFFF);
        bus_write(8'h26, 16'h0000);
        bus_read(8'h26, d); check("R9 write ignored pend", d, 16'h8000 | 16'(TB + 5));
        bus_read(8'h28, d); check("R9 write ignored mask", d, 16'h0000);
        drain("R9 drain");
        bus_read(8'h24, d); check("R9 empty poll", d, 16'h0000);
        bus_read(8'h26, d); check("R9 empty poll nop", d, 16'h0000);

        // Sweep every pending pattern with a varying mask (R1 R2 R4 R6 R7)
        for (int p = 0; p < 256; p++) begin
            logic [N-1:0] m;
            m = N'(p * 37 + 11);
            bus_write(8'h28, 16'(m)); mdl_mask = m;
            bus_read(8'h28, d); check("R3 sweep mask", d, 16'(m));
            pulse(N'(p)); mdl_pend = N'(p);
            bus_read(8'h26, d); check("R7 peek first", d, exp_word(mdl_pend, mdl_mask));
            bus_read(8'h26, d); check("R7 peek repeat", d, exp_word(mdl_pend, mdl_mask));
            drain("R1 R6 sweep drain");
            bus_write(8'h28, 16'h0000); mdl_mask = '0;
            drain("R2 sweep masked remainder");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule